// File: doc/BRIEF.md
# Dual Synthesizer Serial Control Register File

This block is the programming front end of a two-channel frequency synthesizer. A host drives three wires: a serial clock, serial data and a latch strobe. Data bits shift into a 21-bit register, most significant bit first. A rising edge on the latch strobe copies the assembled word into one of four holding registers. The two bits shifted in last choose which one.

The holding registers supply each channel's reference divide, main divide and swallow count, plus a five-bit mode field for each channel. The block decodes the mode fields into gating signals for the synthesizer core:
- a channel enable, an RF-input enable and a charge-pump high-impedance request for each channel;
- reference counter enables;
- a shared reference-input enable and a lock-output enable;
- the phase-detector polarity, a four-bit lock-output select and a test-mode flag.

All three serial inputs pass through synchronizers into the system clock domain. The shift and latch logic keep running whatever the power-down settings are.

Top module: `pll_serial_ctl`

## Requirements
- R1: A rising serial-clock edge shifts the data bit into bit 0 of a 21-bit register, so the first bit sent ends at bit 20. Bits 1 and 0 (last two shifted in) form the address: 2'b11 channel-1 divide word, 2'b10 channel-1 control word, 2'b01 channel-2 divide word, 2'b00 channel-2 control word.
- R2: Holding registers change only on a latch-strobe rising edge. Shifting with the strobe low leaves all outputs unchanged.
- R3: A divide word stores the swallow count from bits 11..7 (MSB at 11, plain binary 0 to 31) and the main divide from bits 20..12 of the addressed channel.
- R4: A control word stores the reference divide from bits 10..2 and the channel's mode field from bits 15..11. Within the mode field, bit 11 = power off, bit 12 = phase-detector normal (0 = inverted), bit 13 = charge-pump high impedance, and bits 15..14 = lock select.
- R5: A powered-off channel has its channel enable and RF-input enable at 0. A powered-on channel has both at 1. The phase-detector polarity output equals the stored bit.
- R6: The charge-pump high-impedance request of a channel is 1 when its high-impedance bit or its power-off bit is set.
- R7: The reference counter enables, the reference-input enable and the lock-output enable are 1 unless both channels are powered off, in which case all are 0.
- R8: Bit 16 of the channel-2 control word is stored, and the test-mode output equals it.
- R9: After reset, dividers, polarity, lock select and test bit are 0, and both channels are powered off.
- R10: Shifting and latching work while both channels are powered off.
- R11: The lock-select output is {channel-2 bits 15..14, channel-1 bits 15..14}.
- R12: A write changes only the holding register selected by its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| sle_i | input | 1 | Latch strobe, asynchronous |
| ref_div | output | 2x9 | Reference divide per channel (index 0 = channel 1) |
| main_div | output | 2x9 | Main divide per channel |
| swallow | output | 2x5 | Swallow count per channel |
| chan_en | output | 2 | Channel enable per channel |
| pd_normal | output | 2 | Phase-detector normal polarity per channel |
| cp_hiz | output | 2 | Charge-pump high-impedance request per channel |
| rf_in_en | output | 2 | RF input enable per channel |
| ref_cnt_en | output | 2 | Reference counter enable per channel |
| ref_in_en | output | 1 | Shared reference input enable |
| lock_out_en | output | 1 | Lock output enable |
| lock_sel | output | 4 | Lock-output select, passed through |
| test_mode | output | 1 | Stored test bit |

## Verification
Each serial input crosses two synchronizer flops and then an edge-detect flop. A shift or a holding-register write therefore happens on the third system-clock edge after the serial-clock or strobe edge. The gating outputs follow the holding registers with no further register.

The bench holds each serial-clock level and each strobe pulse for four system clocks. It samples one nanosecond after a clock edge, and only once at least six clocks have passed since the strobe fell. The no-latch checks read the outputs after a full word has been shifted and before any strobe.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
   localparam int WORD_W = 21;

   typedef enum logic [1:0] {
      ADR_CH2_CTL = 2'b00,
      ADR_CH2_DIV = 2'b01,
      ADR_CH1_CTL = 2'b10,
      ADR_CH1_DIV = 2'b11
   } word_addr_e;

   // field placement inside the 21-bit word
   localparam int POS_MAIN_LO = 12;
   localparam int POS_SWAL_LO = 7;
   localparam int POS_REF_LO  = 2;
   localparam int POS_MODE_LO = 11;
   localparam int POS_TEST    = 16;
   localparam int MAX_MAIN_W  = 9;
   localparam int MAX_SWAL_W  = 5;
   localparam int MAX_REF_W   = 9;
   localparam int MODE_W      = 5;

   typedef struct packed {
      logic [1:0] lock_sel;
      logic       cp_hiz;
      logic       pd_normal;
      logic       power_off;
   } chan_mode_t;

   localparam chan_mode_t MODE_RST = '{lock_sel: 2'b00, cp_hiz: 1'b0,
                                       pd_normal: 1'b0, power_off: 1'b1};
endpackage

// File: rtl/pll_ser_sync.sv
module pll_ser_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] async_i,
   output logic [N-1:0] level_o,
   output logic [N-1:0] rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pll_ser_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [N-1:0] prev_q;

   for (genvar b = 0; b < N; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
      assign level_o[b] = chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_o;
   end

   assign rise_o = level_o & ~prev_q;
endmodule

// File: rtl/pll_ser_shift.sv
module pll_ser_shift #(
   parameter int W = pll_ctl_pkg::WORD_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_stb,
   input  logic         din,
   output logic [W-1:0] word_o
);
   generate
      if (W < 3) begin : g_bad_w
         $error("pll_ser_shift: word too narrow");
      end
   endgenerate

   logic [W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sr_q <= '0;
      else if (shift_stb) sr_q <= {sr_q[W-2:0], din};
   end

   assign word_o = sr_q;

   // R1: the newest bit lands at position 0
   a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      shift_stb |=> (sr_q[0] == $past(din)));
endmodule

// File: rtl/pll_hold_regs.sv
module pll_hold_regs
   import pll_ctl_pkg::*;
#(
   parameter int W      = WORD_W,
   parameter int REF_W  = 9,
   parameter int MAIN_W = 9,
   parameter int SWAL_W = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_stb,
   input  logic [W-1:0]               word_i,
   output logic [1:0][REF_W-1:0]      ref_o,
   output logic [1:0][MAIN_W-1:0]     main_o,
   output logic [1:0][SWAL_W-1:0]     swal_o,
   output chan_mode_t [1:0]           mode_o,
   output logic                       test_o
);
   generate
      if (REF_W > MAX_REF_W || MAIN_W > MAX_MAIN_W || SWAL_W > MAX_SWAL_W) begin : g_bad_fields
         $error("pll_hold_regs: field width exceeds its slot");
      end
   endgenerate

   word_addr_e adr;
   assign adr = word_addr_e'(word_i[1:0]);

   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      localparam word_addr_e CTL_ADR = (ch == 0) ? ADR_CH1_CTL : ADR_CH2_CTL;
      localparam word_addr_e DIV_ADR = (ch == 0) ? ADR_CH1_DIV : ADR_CH2_DIV;

      logic ctl_wr, div_wr;
      assign ctl_wr = wr_stb && (adr == CTL_ADR);
      assign div_wr = wr_stb && (adr == DIV_ADR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ref_o[ch]  <= '0;
            mode_o[ch] <= MODE_RST;
         end else if (ctl_wr) begin
            ref_o[ch]  <= word_i[POS_REF_LO +: REF_W];
            mode_o[ch] <= chan_mode_t'(word_i[POS_MODE_LO +: MODE_W]);
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            main_o[ch] <= '0;
            swal_o[ch] <= '0;
         end else if (div_wr) begin
            main_o[ch] <= word_i[POS_MAIN_LO +: MAIN_W];
            swal_o[ch] <= word_i[POS_SWAL_LO +: SWAL_W];
         end
      end

      // R12: a divide write leaves this channel's control register alone
      a_r12_ctl_kept: assert property (@(posedge clk) disable iff (!rst_n)
         div_wr |=> $stable(mode_o[ch]) && $stable(ref_o[ch]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             test_o <= 1'b0;
      else if (wr_stb && adr == ADR_CH2_CTL)  test_o <= word_i[POS_TEST];
   end

   // R2: without a strobe nothing held may move
   a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(mode_o) && $stable(ref_o) && $stable(main_o)
                  && $stable(swal_o) && $stable(test_o));
endmodule

// File: rtl/pll_gating.sv
module pll_gating
   import pll_ctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  chan_mode_t [1:0] mode_i,
   output logic [1:0]       chan_en_o,
   output logic [1:0]       pd_normal_o,
   output logic [1:0]       cp_hiz_o,
   output logic [1:0]       rf_in_en_o,
   output logic [1:0]       ref_cnt_en_o,
   output logic             ref_in_en_o,
   output logic             lock_out_en_o,
   output logic [3:0]       lock_sel_o
);
   logic all_off;
   assign all_off = mode_i[0].power_off && mode_i[1].power_off;

   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      assign chan_en_o[ch]    = !mode_i[ch].power_off;
      assign rf_in_en_o[ch]   = !mode_i[ch].power_off;
      assign cp_hiz_o[ch]     = mode_i[ch].cp_hiz || mode_i[ch].power_off;
      assign pd_normal_o[ch]  = mode_i[ch].pd_normal;
      assign ref_cnt_en_o[ch] = !all_off;
      assign lock_sel_o[2*ch +: 2] = mode_i[ch].lock_sel;

      // R6: a disabled channel never drives its charge pump
      a_r6_off_hiz: assert property (@(posedge clk) disable iff (!rst_n)
         !chan_en_o[ch] |-> cp_hiz_o[ch]);
      // R5: RF input follows the channel enable
      a_r5_rf_follows: assert property (@(posedge clk) disable iff (!rst_n)
         rf_in_en_o[ch] == chan_en_o[ch]);
   end

   assign ref_in_en_o   = !all_off;
   assign lock_out_en_o = !all_off;

   // R7: shared path is off exactly when no channel is on
   a_r7_shared_off: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en_o == 2'b00) |-> (!ref_in_en_o && !lock_out_en_o && ref_cnt_en_o == 2'b00));
   a_r7_shared_on: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en_o != 2'b00) |-> (ref_in_en_o && lock_out_en_o));
endmodule

// File: rtl/pll_serial_ctl.sv
module pll_serial_ctl
   import pll_ctl_pkg::*;
#(
   parameter int REF_W       = 9,
   parameter int MAIN_W      = 9,
   parameter int SWAL_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sclk_i,
   input  logic                   sdata_i,
   input  logic                   sle_i,
   output logic [1:0][REF_W-1:0]  ref_div,
   output logic [1:0][MAIN_W-1:0] main_div,
   output logic [1:0][SWAL_W-1:0] swallow,
   output logic [1:0]             chan_en,
   output logic [1:0]             pd_normal,
   output logic [1:0]             cp_hiz,
   output logic [1:0]             rf_in_en,
   output logic [1:0]             ref_cnt_en,
   output logic                   ref_in_en,
   output logic                   lock_out_en,
   output logic [3:0]             lock_sel,
   output logic                   test_mode
);
   localparam int IDX_CLK = 0;
   localparam int IDX_DAT = 1;
   localparam int IDX_LE  = 2;

   logic [2:0]        sync_lvl, sync_rise;
   logic [WORD_W-1:0] word;
   chan_mode_t [1:0]  mode;

   pll_ser_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({sle_i, sdata_i, sclk_i}),
      .level_o (sync_lvl),
      .rise_o  (sync_rise)
   );

   pll_ser_shift #(.W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_stb (sync_rise[IDX_CLK]),
      .din       (sync_lvl[IDX_DAT]),
      .word_o    (word)
   );

   pll_hold_regs #(.W(WORD_W), .REF_W(REF_W), .MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (sync_rise[IDX_LE]),
      .word_i (word),
      .ref_o  (ref_div),
      .main_o (main_div),
      .swal_o (swallow),
      .mode_o (mode),
      .test_o (test_mode)
   );

   pll_gating u_gate (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_i        (mode),
      .chan_en_o     (chan_en),
      .pd_normal_o   (pd_normal),
      .cp_hiz_o      (cp_hiz),
      .rf_in_en_o    (rf_in_en),
      .ref_cnt_en_o  (ref_cnt_en),
      .ref_in_en_o   (ref_in_en),
      .lock_out_en_o (lock_out_en),
      .lock_sel_o    (lock_sel)
   );
endmodule

// File: tb/tb_pll_serial_ctl.sv
module tb_pll_serial_ctl;
   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
   logic [1:0][8:0] ref_div, main_div;
   logic [1:0][4:0] swallow;
   logic [1:0] chan_en, pd_normal, cp_hiz, rf_in_en, ref_cnt_en;
   logic ref_in_en, lock_out_en, test_mode;
   logic [3:0] lock_sel;
   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pll_serial_ctl dut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sle_i(sle),
      .ref_div(ref_div), .main_div(main_div), .swallow(swallow),
      .chan_en(chan_en), .pd_normal(pd_normal), .cp_hiz(cp_hiz),
      .rf_in_en(rf_in_en), .ref_cnt_en(ref_cnt_en), .ref_in_en(ref_in_en),
      .lock_out_en(lock_out_en), .lock_sel(lock_sel), .test_mode(test_mode));

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [20:0] div_word(input logic [1:0] a, input logic [8:0] m, input logic [4:0] s);
      return {m, s, 5'b0, a};
   endfunction

   function automatic logic [20:0] ctl_word(input logic [1:0] a, input logic t, input logic [4:0] md, input logic [8:0] r);
      return {4'b0, t, md, r, a};
   endfunction

   task automatic shift_word(input logic [20:0] w);
      for (int i = 20; i >= 0; i--) begin
         sdata = w[i];
         tick(2);
         sclk = 1'b1;
         tick(4);
         sclk = 1'b0;
         tick(2);
      end
   endtask

   task automatic latch();
      sle = 1'b1;
      tick(4);
      sle = 1'b0;
      tick(6);
   endtask

   task automatic send(input logic [20:0] w);
      shift_word(w);
      latch();
   endtask

   task automatic t_reset();
      chk("R9 ref_div", ref_div, 0);
      chk("R9 main_div", main_div, 0);
      chk("R9 swallow", swallow, 0);
      chk("R9 chan_en", chan_en, 2'b00);
      chk("R9 cp_hiz", cp_hiz, 2'b11);
      chk("R9 pd_normal", pd_normal, 2'b00);
      chk("R9 shared", {ref_in_en, lock_out_en, ref_cnt_en}, 4'b0000);
      chk("R9 lock_sel/test", {lock_sel, test_mode}, 5'b0);
   endtask

   task automatic t_ch1_div();
      send(div_word(2'b11, 9'h1A5, 5'd31));
      chk("R3 ch1 main", main_div[0], 9'h1A5);
      chk("R3 ch1 swallow max", swallow[0], 5'd31);
      chk("R12 ch2 div untouched", {main_div[1], swallow[1]}, 0);
      chk("R10 both off still programs", chan_en, 2'b00);
   endtask

   task automatic t_no_latch();
      shift_word(div_word(2'b11, 9'h0F0, 5'd0));
      chk("R2 no strobe main", main_div[0], 9'h1A5);
      chk("R2 no strobe swallow", swallow[0], 5'd31);
      latch();
      chk("R1 shifted word latched main", main_div[0], 9'h0F0);
      chk("R3 swallow zero", swallow[0], 5'd0);
   endtask

   task automatic t_ch1_on();
      send(ctl_word(2'b10, 1'b0, 5'b10010, 9'h155));
      chk("R4 ch1 ref", ref_div[0], 9'h155);
      chk("R5 ch1 on", {chan_en[0], rf_in_en[0]}, 2'b11);
      chk("R5 ch2 still off", {chan_en[1], rf_in_en[1]}, 2'b00);
      chk("R6 cp hiz", cp_hiz, 2'b10);
      chk("R5 polarity", pd_normal, 2'b01);
      chk("R7 one on", {ref_in_en, lock_out_en, ref_cnt_en}, 4'b1111);
      chk("R11 lock sel ch1", lock_sel, 4'b0010);
   endtask

   task automatic t_ch2_ctl();
      send(ctl_word(2'b00, 1'b0, 5'b01100, 9'h0AA));
      chk("R4 ch2 ref", ref_div[1], 9'h0AA);
      chk("R6 on but hiz", {chan_en[1], cp_hiz[1]}, 2'b11);
      chk("R5 inverted polarity", pd_normal[1], 1'b0);
      chk("R11 lock sel both", lock_sel, 4'b0110);
      chk("R12 ch1 ref kept", ref_div[0], 9'h155);
      chk("R8 test low", test_mode, 1'b0);
   endtask

   task automatic t_ch2_div();
      send(div_word(2'b01, 9'h1FF, 5'd17));
      chk("R3 ch2 main", main_div[1], 9'h1FF);
      chk("R3 ch2 swallow", swallow[1], 5'd17);
      chk("R12 ch1 div kept", {main_div[0], swallow[0]}, {9'h0F0, 5'd0});
   endtask

   task automatic t_test_bit();
      send(ctl_word(2'b00, 1'b1, 5'b01100, 9'h0AA));
      chk("R8 test high", test_mode, 1'b1);
      send(ctl_word(2'b00, 1'b0, 5'b01100, 9'h0AA));
      chk("R8 test cleared", test_mode, 1'b0);
   endtask

   task automatic t_all_off();
      send(ctl_word(2'b10, 1'b0, 5'b10011, 9'h155));
      chk("R7 ch2 alone keeps shared", {ref_in_en, lock_out_en, ref_cnt_en}, 4'b1111);
      chk("R6 ch1 off hiz", cp_hiz[0], 1'b1);
      send(ctl_word(2'b00, 1'b0, 5'b01001, 9'h0AA));
      chk("R7 all off", {ref_in_en, lock_out_en, ref_cnt_en}, 4'b0000);
      chk("R5 all off", {chan_en, rf_in_en}, 4'b0000);
      send(div_word(2'b11, 9'h003, 5'd1));
      chk("R10 program while off", {main_div[0], swallow[0]}, {9'h003, 5'd1});
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_ch1_div();
      t_no_latch();
      t_ch1_on();
      t_ch2_ctl();
      t_ch2_div();
      t_test_bit();
      t_all_off();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule